// File: doc/BRIEF.md
# Synchronous Burst SRAM

A cycle-accurate, synthesizable model of a clocked static RAM with a built-in four-beat burst sequencer. The word is 18 bits wide, split into two 9-bit byte lanes, and the depth is a parameter kept small. Address, strobes, chip enables and write data are captured on the rising clock edge. The output enable and the sleep input act without a clock. A command registered with a load strobe starts a burst. Later beats are stepped internally by an advance strobe, in either linear or interleaved order.

A static mode input picks one of two read latencies. With the mode low, the memory array drives the bus straight from the registered address (flow-through, 2-1-1-1). With the mode high, an extra output register sits in the path (pipelined, 3-1-1-1). A deselect turns the outputs off one stage earlier than a read would have delivered data. The shared data pins are modelled as a separate input bus and output bus with a drive-enable, which is how the block is wired inside a larger chip.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is active, and after its release until a read is registered, `dq_oe` is 0 and `dq_out` is 0.
- R2: With `pipe_mode` low, a selected read registered at edge E puts the word at its address on `dq_out` with `dq_oe` high right after E.
- R3: With `pipe_mode` high, a selected read registered at edge E delivers its word right after edge E+1.
- R4: Burst beat b (0..3) addresses the upper address bits of the load unchanged. The low two bits are (base + b) mod 4 when `burst_linear` is 1, and base XOR b when it is 0. Each edge with `load_n` high and `adv_n` low steps one beat.
- R5: With `gwe_n` high and `bwe_n` low, lane 0 (bits 8:0) is written when `bsel_n[0]` is 0 and lane 1 (bits 17:9) when `bsel_n[1]` is 0. An unselected lane keeps its contents.
- R6: With `gwe_n` low, both lanes are written whatever `bwe_n` and `bsel_n` are.
- R7: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load strobe while unselected writes nothing and ends any burst.
- R8: After a deselect is registered at edge E, `dq_oe` is 0 right after E in both modes. A pipelined read registered at E-1 is therefore never driven.
- R9: `oe_n` high forces `dq_oe` to 0 and `dq_out` to 0 at once. Lowering it restores the read data with no clock edge.
- R10: `sleep` high forces `dq_oe` low at once and makes every edge ignore commands. Memory and burst state are retained, so a burst read resumes on wake.
- R11: An edge with `load_n` and `adv_n` both high holds the burst address. A read keeps returning the same word, and a write burst writes nothing on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| burst_linear | input | 1 | 1 linear burst order, 0 interleaved |
| sleep | input | 1 | Asynchronous low-power request |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Load strobe: registers a new command and address |
| adv_n | input | 1 | Advance strobe: steps the burst |
| gwe_n | input | 1 | Global write, all lanes |
| bwe_n | input | 1 | Byte-write enable |
| bsel_n | input | 2 | Per-lane byte selects, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 18 | Write data |
| dq_out | output | 18 | Read data, 0 when not driving |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Inputs change just after a falling edge and are taken by the following rising edge E. Each result is then read at the falling edge where it is due. Flow-through read data is sampled at the falling edge after E and pipelined data one full cycle later. Written words are checked by a later read. A deselect is checked at the first falling edge after the edge that registered it. Output enable and sleep are asynchronous, so they are checked 1 ns after the input changes, with no clock edge in between. The bench keeps a word-by-word model of the array and works out each beat address from the order rule, so every sample is compared against the exact beat due in that cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANE_W  = 9;
  localparam int LANES   = 2;
  localparam int BURST_W = 2;

  // low address bits of a burst beat
  function automatic logic [BURST_W-1:0] beat_lo(input logic [BURST_W-1:0] base,
                                                 input logic [BURST_W-1:0] cnt,
                                                 input logic               linear);
    return linear ? BURST_W'(base + cnt) : (base ^ cnt);
  endfunction
endpackage

// File: rtl/sbs_rst_sync.sv
module sbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-1:0] ld_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0]      base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = ld_addr;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d  = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_addr  = {base_q[AW-1:BURST_W], beat_lo(base_q[BURST_W-1:0], cnt_q,   linear)};
  assign next_addr = {base_q[AW-1:BURST_W], beat_lo(base_q[BURST_W-1:0], cnt_inc, linear)};
endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    burst_linear,
  input  logic                    sleep,
  input  logic                    oe_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    load_n,
  input  logic                    adv_n,
  input  logic                    gwe_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              rst_i;
  logic              awake, sel, load, step, wr_req;
  logic [LANES-1:0]  lane_sel, mem_we;
  logic [ADDR_W-1:0] cur_addr, next_addr, waddr;
  logic [DATA_W-1:0] rd_data;

  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic              rd1_q, rd1_d;
  logic              rd2_q, rd2_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              drive;

  sbs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i));

  assign awake    = !sleep;
  assign sel      = !ce1_n && ce2 && !ce3_n;
  assign load     = !load_n;
  assign step     = load_n && !adv_n && act_q;
  assign lane_sel = !gwe_n ? '1 : (!bwe_n ? ~bsel_n : '0);
  assign wr_req   = |lane_sel;

  always_comb begin
    mem_we = '0;
    if (awake && ((load && sel) || (step && wr_q))) mem_we = lane_sel;
  end
  assign waddr = load ? addr : next_addr;

  sbs_burst_gen #(.AW(ADDR_W)) u_gen (
    .clk(clk), .rst_n(rst_i), .en(awake), .load(load && sel), .step(step),
    .linear(burst_linear), .ld_addr(addr), .cur_addr(cur_addr), .next_addr(next_addr)
  );

  sbs_store #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(dq_in),
    .raddr(cur_addr), .rdata(rd_data)
  );

  // next state of the command pipeline
  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    rd1_d  = rd1_q;
    rd2_d  = rd1_q;
    dout_d = rd_data;
    if (load) begin
      if (sel) begin
        act_d = 1'b1;
        wr_d  = wr_req;
        rd1_d = !wr_req;
      end else begin
        act_d = 1'b0;
        wr_d  = 1'b0;
        rd1_d = 1'b0;
        rd2_d = 1'b0;   // single-cycle deselect: kill the output stage too
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      rd1_q  <= 1'b0;
      rd2_q  <= 1'b0;
      dout_q <= '0;
    end else if (awake) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      rd1_q  <= rd1_d;
      rd2_q  <= rd2_d;
      dout_q <= dout_d;
    end
  end

  assign drive  = pipe_mode ? rd2_q : rd1_q;
  assign dq_oe  = drive && !oe_n && !sleep;
  assign dq_out = dq_oe ? (pipe_mode ? dout_q : rd_data) : '0;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pipe_mode,
  input logic        burst_linear,
  input logic        sleep,
  input logic        oe_n,
  input logic        ce1_n,
  input logic        ce2,
  input logic        ce3_n,
  input logic        load_n,
  input logic        adv_n,
  input logic        gwe_n,
  input logic [17:0] dq_out,
  input logic        dq_oe
);
  logic chip_on;
  assign chip_on = !ce1_n && ce2 && !ce3_n;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!dq_oe && dq_out == '0)); // R1
  AST_FLOW_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !sleep && !load_n && chip_on && !gwe_n) |=> !dq_oe); // R6
  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !load_n && !chip_on) |=> !dq_oe); // R8
  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_oe && dq_out == '0)); // R9
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !sleep && load_n && adv_n && dq_oe)
      |=> (!dq_oe || !$stable(burst_linear) || $stable(dq_out))); // R11
endmodule

bind sync_burst_sram sbs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_linear(burst_linear),
  .sleep(sleep), .oe_n(oe_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .load_n(load_n), .adv_n(adv_n), .gwe_n(gwe_n), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pipe_mode, burst_linear, sleep, oe_n;
  logic        ce1_n, ce2, ce3_n, load_n, adv_n, gwe_n, bwe_n;
  logic [1:0]  bsel_n;
  logic [5:0]  addr;
  logic [17:0] dq_in, dq_out;
  logic        dq_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [17:0] exp_mem [64];

  always #4 clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_linear(burst_linear),
    .sleep(sleep), .oe_n(oe_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .load_n(load_n), .adv_n(adv_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [5:0] beat_addr(input logic [5:0] a, input int b, input logic lin);
    logic [1:0] bb = 2'(b);
    return {a[5:2], lin ? 2'(a[1:0] + bb) : (a[1:0] ^ bb)};
  endfunction

  function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] d,
                                        input logic gw_n, input logic bw_n, input logic [1:0] bs_n);
    logic [1:0]  ln = !gw_n ? 2'b11 : (!bw_n ? ~bs_n : 2'b00);
    logic [17:0] r  = old;
    if (ln[0]) r[8:0]  = d[8:0];
    if (ln[1]) r[17:9] = d[17:9];
    return r;
  endfunction

  task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    load_n = 1; adv_n = 1; gwe_n = 1; bwe_n = 1; bsel_n = 2'b11;
    ce1_n = 0; ce2 = 1; ce3_n = 0;
  endtask

  task automatic deselect();
    ce2 = 0; load_n = 0; adv_n = 1;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic set_mode(input logic m);
    deselect();
    pipe_mode = m;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [17:0] d, input logic gw_n,
                    input logic bw_n, input logic [1:0] bs_n, input logic [2:0] ce);
    addr = a; dq_in = d; gwe_n = gw_n; bwe_n = bw_n; bsel_n = bs_n;
    {ce1_n, ce2, ce3_n} = ce; load_n = 0; adv_n = 1;
    @(negedge clk);
    if (ce == 3'b010) exp_mem[a] = merge(exp_mem[a], d, gw_n, bw_n, bs_n);
    idle_inputs();
    if (ce != 3'b010) deselect();
  endtask

  task automatic rd_burst(input string req, input logic [5:0] a, input int len, input logic lin);
    int lat = pipe_mode ? 2 : 1;
    for (int c = 0; c < len + lat; c++) begin
      if (c >= lat) begin
        chk(req, {17'd0, dq_oe}, 18'd1);
        chk(req, dq_out, exp_mem[beat_addr(a, c - lat, lin)]);
      end
      if (c == 0) begin
        addr = a; burst_linear = lin; load_n = 0; adv_n = 1;
      end else if (c < len) begin
        load_n = 1; adv_n = 0;
      end else begin
        load_n = 1; adv_n = 1;
      end
      @(negedge clk);
    end
    idle_inputs();
    deselect();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] d0, d1;
    void'($urandom(32'd2024));
    rst_n = 0; pipe_mode = 0; burst_linear = 1; sleep = 0; oe_n = 0;
    addr = '0; dq_in = '0;
    idle_inputs();
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", {17'd0, dq_oe}, 18'd0);
    chk("R1 data in reset", dq_out, 18'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 oe after release", {17'd0, dq_oe}, 18'd0);

    for (int i = 0; i < 64; i++) wr(6'(i), 18'($urandom), 0, 1, 2'b11, 3'b010);

    // R2 flow-through and R3 pipelined single reads
    rd_burst("R2", 6'd5, 1, 1);
    set_mode(1);
    rd_burst("R3", 6'd9, 1, 1);
    // R4 orders: base low bits 1 -> linear 1,2,3,0 ; interleaved 1,0,3,2
    rd_burst("R4 linear", 6'd5, 4, 1);
    rd_burst("R4 interleaved", 6'd5, 4, 0);
    set_mode(0);
    rd_burst("R4 flow interleaved", 6'd14, 4, 0);

    // R5 byte lanes
    wr(6'd10, 18'h2AAAA, 1, 0, 2'b10, 3'b010);
    rd_burst("R5 lane0", 6'd10, 1, 1);
    wr(6'd10, 18'h15555, 1, 0, 2'b01, 3'b010);
    rd_burst("R5 lane1", 6'd10, 1, 1);
    // R6 global write overrides byte controls
    wr(6'd11, 18'h3C3C3, 0, 1, 2'b11, 3'b010);
    rd_burst("R6 global", 6'd11, 1, 1);
    wr(6'd11, 18'h0F0F0, 0, 0, 2'b10, 3'b010);
    rd_burst("R6 global over bytes", 6'd11, 1, 1);

    // R7 each disabling enable blocks a write
    wr(6'd12, 18'h11111, 0, 1, 2'b11, 3'b110);
    wr(6'd12, 18'h22222, 0, 1, 2'b11, 3'b000);
    wr(6'd12, 18'h33333, 0, 1, 2'b11, 3'b011);
    rd_burst("R7 unselected", 6'd12, 1, 1);

    // R8 single-cycle deselect, pipelined read cut off
    set_mode(1);
    addr = 6'd13; load_n = 0; @(negedge clk);
    idle_inputs(); ce2 = 0; load_n = 0; @(negedge clk);
    idle_inputs();
    chk("R8 pipe", {17'd0, dq_oe}, 18'd0);
    set_mode(0);
    addr = 6'd13; load_n = 0; @(negedge clk);
    idle_inputs();
    chk("R8 flow on", dq_out, exp_mem[13]);
    ce2 = 0; load_n = 0; @(negedge clk);
    idle_inputs();
    chk("R8 flow off", {17'd0, dq_oe}, 18'd0);

    // R9 asynchronous output enable
    addr = 6'd31; load_n = 0; @(negedge clk);
    idle_inputs();
    oe_n = 1; #1;
    chk("R9 oe off", {17'd0, dq_oe}, 18'd0);
    chk("R9 data zero", dq_out, 18'd0);
    oe_n = 0; #1;
    chk("R9 restore", dq_out, exp_mem[31]);
    @(negedge clk); deselect();

    // R10 sleep: async off, command ignored, state kept
    addr = 6'd30; burst_linear = 1; load_n = 0; @(negedge clk);
    idle_inputs();
    sleep = 1; #1;
    chk("R10 async off", {17'd0, dq_oe}, 18'd0);
    @(negedge clk);
    addr = 6'd30; dq_in = ~exp_mem[30]; gwe_n = 0; load_n = 0; @(negedge clk);
    idle_inputs(); @(negedge clk);
    chk("R10 still off", {17'd0, dq_oe}, 18'd0);
    sleep = 0; #1;
    chk("R10 resume oe", {17'd0, dq_oe}, 18'd1);
    chk("R10 retained", dq_out, exp_mem[30]);
    @(negedge clk); deselect();
    rd_burst("R10 readback", 6'd30, 1, 1);

    // R11 hold during a read and during a write burst
    addr = 6'd24; burst_linear = 1; load_n = 0; @(negedge clk);
    load_n = 1; adv_n = 1; @(negedge clk);
    chk("R11 read hold", dq_out, exp_mem[24]);
    adv_n = 0; @(negedge clk);
    chk("R11 read step", dq_out, exp_mem[25]);
    idle_inputs(); deselect();
    d0 = 18'($urandom); d1 = 18'($urandom);
    addr = 6'd40; dq_in = d0; gwe_n = 0; load_n = 0; @(negedge clk);
    load_n = 1; adv_n = 1; dq_in = ~d0; @(negedge clk);
    adv_n = 0; dq_in = d1; @(negedge clk);
    idle_inputs();
    exp_mem[40] = d0; exp_mem[41] = d1;
    rd_burst("R11 write hold", 6'd40, 4, 1);

    // random mix
    for (int it = 0; it < 250; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) begin
        logic [2:0] ce = ($urandom_range(0, 4) == 0) ? 3'($urandom_range(0, 7)) : 3'b010;
        wr(6'($urandom), 18'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom),
           2'($urandom), ce);
      end else if (op < 9) begin
        rd_burst(pipe_mode ? "R3 R4 random" : "R2 R4 random", 6'($urandom),
                 $urandom_range(1, 4), 1'($urandom));
      end else begin
        set_mode(~pipe_mode);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule